// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes a received frame from a byte stream and places it in memory through a ring of 8-byte receive descriptors. While the frame streams in, the block keeps the bytes in a local store and runs a CRC-32 over them. At the end of the frame it appends the four CRC bytes to the payload. It first walks the ring from its current position to confirm that the empty descriptors can hold the whole frame. Only then does it split the frame into chunks of the programmed buffer size, write each chunk to the buffer its descriptor names, and write each descriptor back.

Software fills the ring, sets `enable` and pulses `rx_kick` once descriptors are ready. The block then reads the descriptor at its current position and becomes active if that descriptor is empty. It stays active only while the descriptor after each stored frame is still empty. When it is not active, arriving frames are accepted and dropped.

The frame interface is valid/ready. A beat transfers when `in_valid` and `in_ready` are both high. `in_valid` may be asserted at any time, and the beat is held until it transfers. From the beat that ends a stored frame until that frame has been written out or dropped, `in_ready` stays low. Apart from that window, `in_ready` is high, including while frames are being discarded.

Top module: `rxs_engine`

## Requirements
- R1: Out of reset, `rx_active`, `mem_req`, `evt_buf` and `evt_frame` are low and `in_ready` is high.
- R2: With `enable` high and the block inactive, a pulse on `rx_kick` reads the descriptor at the current position, and the block becomes active exactly when that descriptor's empty bit is set. While `enable` is low the block is inactive, issues no memory writes, and its current position is `ring_base`, which must be 8-byte aligned.
- R3: While inactive, stream beats are accepted (`in_ready` high) and dropped, with no memory write and no event.
- R4: A descriptor is two big-endian 32-bit words. The word at offset 0 holds flags in bits 31:16 and length in bits 15:0. The word at offset 4 holds the buffer byte address. Flag bits are: 15 empty, 13 wrap, 11 last, 5 length violation, 0 truncated. Buffer bytes are stored in order of increasing address, with the lowest address on bits 31:24 of a word.
- R5: After the data, four CRC bytes are stored, most significant byte first, and they count in the frame length. The CRC is the Ethernet CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, result inverted) over the stored data bytes.
- R6: The buffer size is `buf_units` times 16 bytes, and a value of 0 selects 0x7F0 bytes. Each descriptor receives the smaller of the remaining length and the buffer size.
- R7: If the empty descriptors reached from the current position, following the wrap bit, cannot hold the whole frame, the frame is dropped. No memory write or event results, and the block stays active.
- R8: Each filled descriptor gets its length written and its empty bit cleared, and its other flags are kept. A descriptor that is not final pulses `evt_buf`. The final descriptor also gets the last bit and the violation flags, and pulses `evt_frame`. The CRC may be split across descriptors.
- R9: After a descriptor whose wrap bit is set, the next one is at `ring_base`. Otherwise the next one is 8 bytes further on.
- R10: When the stored length including the CRC exceeds `len_limit`, bit 5 is set, and only in the final descriptor.
- R11: Data beyond MAX_FRAME-4 bytes is dropped, so the stored length is MAX_FRAME. The final descriptor then gets both bit 0 and bit 5.
- R12: After a frame is stored, the block reads the next descriptor and stays active only if that descriptor's empty bit is set.
- R13: From the last beat of a stored frame until the frame is written or dropped, `in_ready` is low and the captured frame does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receive enable; low disables and rewinds to ring_base |
| rx_kick | input | 1 | Pulse: descriptors are ready |
| ring_base | input | 32 | Byte address of the first descriptor |
| buf_units | input | 7 | Buffer size in 16-byte units, 0 = 0x7F0 bytes |
| len_limit | input | 16 | Length above which bit 5 is set |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lanes, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| rx_active | output | 1 | Receive active |
| evt_buf | output | 1 | Pulse: a non-final descriptor was filled |
| evt_frame | output | 1 | Pulse: a frame was completed |

## Verification
The bench builds the block with MAX_FRAME set to 96, so a 100-byte frame is enough to reach truncation. With that setting the store holds 92 data bytes. Buffer sizes of 16, 32 and 64 bytes come from `buf_units` values 1, 2 and 4, which lets short frames span several descriptors. They also place the CRC across a descriptor boundary and let a four-entry ring wrap. A `buf_units` value of 0 checks the 0x7F0 default with a frame that fits one descriptor.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int FL_EMPTY = 15;
  localparam int FL_WRAP  = 13;
  localparam int FL_LAST  = 11;
  localparam int FL_LONG  = 5;
  localparam int FL_TRUNC = 0;
  localparam int DESC_BYTES = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE_RD, S_PROBE_WT, S_SCAN_RD, S_SCAN_WT,
    S_D_RD0, S_D_RD1, S_D_WT, S_DATA, S_WB, S_NEXT_RD, S_NEXT_WT
  } sc_state_e;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxs_crc32.sv
module rxs_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  import rxs_pkg::*;
  logic [31:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '1;
    else if (clr) st_q <= '1;
    else if (en)  st_q <= crc_byte(st_q, din);
  end

  assign fcs = ~st_q;
endmodule

// File: rtl/rxs_frame_store.sv
module rxs_frame_store #(
  parameter int MAX_FRAME = 2032,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [LEN_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             frm_pending,
  output logic [LEN_W-1:0] frm_total,
  output logic             frm_trunc,
  input  logic             frm_ack
);
  localparam int DEPTH = MAX_FRAME - 4;
  localparam int IW    = $clog2(DEPTH);

  logic [7:0]       buf_q [DEPTH];
  logic [LEN_W-1:0] cnt_q;
  logic             in_frame_q, keep_q, pend_q, trunc_q;
  logic             acc, keep_now, room, store_en;
  logic [31:0]      fcs;
  logic [1:0]       off;

  assign in_ready = !pend_q;
  assign acc      = in_valid && in_ready;
  assign keep_now = in_frame_q ? keep_q : keep_en;
  assign room     = cnt_q < LEN_W'(DEPTH);
  assign store_en = acc && keep_now && room;

  rxs_crc32 u_crc (
    .clk (clk), .rst_n (rst_n), .clr (frm_ack), .en (store_en), .din (in_data), .fcs (fcs)
  );

  always_ff @(posedge clk) begin
    if (store_en) buf_q[cnt_q[IW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; in_frame_q <= 1'b0; keep_q <= 1'b0; pend_q <= 1'b0; trunc_q <= 1'b0;
    end else if (frm_ack) begin
      cnt_q <= '0; pend_q <= 1'b0; trunc_q <= 1'b0;
    end else if (acc) begin
      if (store_en) cnt_q <= cnt_q + LEN_W'(1);
      if (keep_now && !room) trunc_q <= 1'b1;
      if (in_last) begin
        in_frame_q <= 1'b0;
        if (keep_now) pend_q <= 1'b1;
      end else begin
        in_frame_q <= 1'b1;
        keep_q     <= keep_now;
      end
    end
  end

  // bytes past the data come from the CRC, most significant first
  assign off = rd_idx[1:0] - cnt_q[1:0];
  always_comb begin
    if (rd_idx < cnt_q) rd_byte = buf_q[rd_idx[IW-1:0]];
    else begin
      unique case (off)
        2'd0:    rd_byte = fcs[31:24];
        2'd1:    rd_byte = fcs[23:16];
        2'd2:    rd_byte = fcs[15:8];
        default: rd_byte = fcs[7:0];
      endcase
    end
  end

  assign frm_pending = pend_q;
  assign frm_total   = cnt_q + LEN_W'(4);
  assign frm_trunc   = trunc_q;

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_W'(DEPTH));
  // R13
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frm_ack) |=> ($stable(cnt_q) && $stable(fcs) && !in_ready));
endmodule

// File: rtl/rxs_scatter_fsm.sv
module rxs_scatter_fsm #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             kick,
  input  logic [31:0]      ring_base,
  input  logic [LEN_W-1:0] mbs,
  input  logic [15:0]      len_limit,
  input  logic             frm_pending,
  input  logic [LEN_W-1:0] frm_total,
  input  logic             frm_trunc,
  output logic             frm_ack,
  output logic [LEN_W-1:0] rd_idx,
  input  logic [7:0]       rd_byte,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             rx_active,
  output logic             evt_buf,
  output logic             evt_frame
);
  import rxs_pkg::*;

  sc_state_e        state_q;
  logic             active_q, lg_q, tr_q;
  logic [31:0]      cur_q, scan_q, wr_q, bufp_q, byte_addr;
  logic [LEN_W-1:0] rem_q, chunk_q, k_q, idx_q;
  logic [15:0]      flags_q, wb_flags;
  logic             last_chunk;

  function automatic logic [31:0] step(input logic [31:0] a, input logic [15:0] f,
                                       input logic [31:0] base);
    return f[FL_WRAP] ? base : a + 32'(DESC_BYTES);
  endfunction

  assign last_chunk = (rem_q == chunk_q);
  assign byte_addr  = bufp_q + 32'(k_q);
  assign rd_idx     = idx_q;

  always_comb begin
    wb_flags = flags_q & ~(16'h1 << FL_EMPTY);
    if (last_chunk) begin
      wb_flags[FL_LAST]  = 1'b1;
      wb_flags[FL_LONG]  = wb_flags[FL_LONG] | lg_q;
      wb_flags[FL_TRUNC] = wb_flags[FL_TRUNC] | tr_q;
    end
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_be = '0; mem_wdata = '0;
    unique case (state_q)
      S_PROBE_RD, S_NEXT_RD: begin mem_req = 1'b1; mem_addr = cur_q; end
      S_SCAN_RD:             begin mem_req = 1'b1; mem_addr = scan_q; end
      S_D_RD0:               begin mem_req = 1'b1; mem_addr = wr_q; end
      S_D_RD1:               begin mem_req = 1'b1; mem_addr = wr_q + 32'd4; end
      S_DATA: begin
        mem_req   = 1'b1; mem_we = 1'b1;
        mem_addr  = {byte_addr[31:2], 2'b00};
        mem_be    = 4'b1000 >> byte_addr[1:0];
        mem_wdata = {4{rd_byte}};
      end
      S_WB: begin
        mem_req   = 1'b1; mem_we = 1'b1; mem_addr = wr_q; mem_be = 4'hF;
        mem_wdata = {wb_flags, 16'(chunk_q)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; active_q <= 1'b0; lg_q <= 1'b0; tr_q <= 1'b0;
      cur_q <= '0; scan_q <= '0; wr_q <= '0; bufp_q <= '0;
      rem_q <= '0; chunk_q <= '0; k_q <= '0; idx_q <= '0; flags_q <= '0;
      frm_ack <= 1'b0; evt_buf <= 1'b0; evt_frame <= 1'b0;
    end else begin
      frm_ack <= 1'b0; evt_buf <= 1'b0; evt_frame <= 1'b0;
      if (!enable) begin
        active_q <= 1'b0;
        cur_q    <= ring_base;
        state_q  <= S_IDLE;
        frm_ack  <= frm_pending && !frm_ack;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (frm_pending && !frm_ack) begin
              if (!active_q) frm_ack <= 1'b1;
              else begin
                rem_q   <= frm_total;
                scan_q  <= cur_q;
                tr_q    <= frm_trunc;
                lg_q    <= frm_trunc || (16'(frm_total) > len_limit);
                state_q <= S_SCAN_RD;
              end
            end else if (kick && !active_q) state_q <= S_PROBE_RD;
          end
          S_PROBE_RD: state_q <= S_PROBE_WT;
          S_PROBE_WT: begin active_q <= mem_rdata[16+FL_EMPTY]; state_q <= S_IDLE; end
          S_SCAN_RD:  state_q <= S_SCAN_WT;
          S_SCAN_WT: begin
            if (!mem_rdata[16+FL_EMPTY]) begin
              frm_ack <= 1'b1; state_q <= S_IDLE;
            end else if (rem_q <= mbs) begin
              rem_q <= frm_total; wr_q <= cur_q; idx_q <= '0; state_q <= S_D_RD0;
            end else begin
              rem_q   <= rem_q - mbs;
              scan_q  <= step(scan_q, mem_rdata[31:16], ring_base);
              state_q <= S_SCAN_RD;
            end
          end
          S_D_RD0: state_q <= S_D_RD1;
          S_D_RD1: begin flags_q <= mem_rdata[31:16]; state_q <= S_D_WT; end
          S_D_WT: begin
            bufp_q  <= mem_rdata;
            chunk_q <= (rem_q < mbs) ? rem_q : mbs;
            k_q     <= '0;
            state_q <= S_DATA;
          end
          S_DATA: begin
            idx_q <= idx_q + LEN_W'(1);
            k_q   <= k_q + LEN_W'(1);
            if (k_q == chunk_q - LEN_W'(1)) state_q <= S_WB;
          end
          S_WB: begin
            rem_q <= rem_q - chunk_q;
            wr_q  <= step(wr_q, flags_q, ring_base);
            if (last_chunk) begin
              evt_frame <= 1'b1; frm_ack <= 1'b1;
              cur_q     <= step(wr_q, flags_q, ring_base);
              state_q   <= S_NEXT_RD;
            end else begin
              evt_buf <= 1'b1; state_q <= S_D_RD0;
            end
          end
          S_NEXT_RD: state_q <= S_NEXT_WT;
          S_NEXT_WT: begin active_q <= mem_rdata[16+FL_EMPTY]; state_q <= S_IDLE; end
          default:   state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign rx_active = active_q;

  // R6
  wb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF) |->
      (mem_wdata[15:0] != 16'd0 && LEN_W'(mem_wdata[15:0]) <= mbs));
  // R2
  off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(mem_req && mem_we));
  // R2
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(mem_rdata[16+FL_EMPTY]));
  // R8
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_buf || evt_frame) |-> $past(mem_req && mem_we && mem_be == 4'hF && !mem_wdata[31]));
endmodule

// File: rtl/rxs_engine.sv
module rxs_engine #(
  parameter int MAX_FRAME = 2032,
  parameter int LEN_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        rx_kick,
  input  logic [31:0] ring_base,
  input  logic [6:0]  buf_units,
  input  logic [15:0] len_limit,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rx_active,
  output logic        evt_buf,
  output logic        evt_frame
);
  localparam logic [LEN_W-1:0] MBS_DEFAULT = LEN_W'(16'h07F0);

  logic [LEN_W-1:0] mbs, frm_total, rd_idx;
  logic             frm_pending, frm_trunc, frm_ack;
  logic [7:0]       rd_byte;

  assign mbs = (buf_units == 7'd0) ? MBS_DEFAULT : LEN_W'({buf_units, 4'b0000});

  rxs_frame_store #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_store (
    .clk (clk), .rst_n (rst_n), .keep_en (rx_active),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data), .in_last (in_last),
    .rd_idx (rd_idx), .rd_byte (rd_byte),
    .frm_pending (frm_pending), .frm_total (frm_total), .frm_trunc (frm_trunc),
    .frm_ack (frm_ack)
  );

  rxs_scatter_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk (clk), .rst_n (rst_n), .enable (enable), .kick (rx_kick),
    .ring_base (ring_base), .mbs (mbs), .len_limit (len_limit),
    .frm_pending (frm_pending), .frm_total (frm_total), .frm_trunc (frm_trunc),
    .frm_ack (frm_ack), .rd_idx (rd_idx), .rd_byte (rd_byte),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_be (mem_be),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .rx_active (rx_active), .evt_buf (evt_buf), .evt_frame (evt_frame)
  );
endmodule

// File: tb/tb_rxs_engine.sv
`timescale 1ns/1ps
module tb_rxs_engine;
  localparam int MAXF = 96;
  localparam logic [31:0] RING = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, rx_kick = 1'b0;
  logic [6:0] buf_units = 7'd2;
  logic [15:0] len_limit = 16'hFFFF;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = 8'h0;
  logic mem_req, mem_we, rx_active, evt_buf, evt_frame;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  logic [7:0] mem [4096];
  logic [7:0] tx [256];
  int nchk = 0, nbad = 0, nbufe = 0, nfrme = 0, nwr = 0;

  always #4 clk = ~clk;

  rxs_engine #(.MAX_FRAME(MAXF)) dut (
    .clk, .rst_n, .enable, .rx_kick, .ring_base(RING), .buf_units, .len_limit,
    .in_valid, .in_ready, .in_data, .in_last,
    .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
    .rx_active, .evt_buf, .evt_frame
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int l = 0; l < 4; l++)
        if (mem_be[3-l]) mem[(mem_addr[11:0] + l) % 4096] <= mem_wdata[31-8*l -: 8];
    end else if (mem_req) begin
      mem_rdata <= {mem[mem_addr[11:0]], mem[mem_addr[11:0]+1],
                    mem[mem_addr[11:0]+2], mem[mem_addr[11:0]+3]};
    end
    if (rst_n) begin
      if (evt_buf) nbufe++;
      if (evt_frame) nfrme++;
      if (mem_req && mem_we) nwr++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input int a);
    return {mem[a], mem[a+1]};
  endfunction

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, tx[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic int dsc(input int i); return 32'h100 + 8 * i; endfunction
  function automatic int bfa(input int i); return 32'h400 + 32'h80 * i; endfunction

  task automatic set_desc(input int i, input logic [15:0] fl);
    mem[dsc(i)] = fl[15:8]; mem[dsc(i)+1] = fl[7:0]; mem[dsc(i)+2] = 8'h0; mem[dsc(i)+3] = 8'h0;
    mem[dsc(i)+4] = 8'h0; mem[dsc(i)+5] = 8'h0;
    mem[dsc(i)+6] = 8'(bfa(i) >> 8); mem[dsc(i)+7] = 8'(bfa(i));
  endtask

  task automatic zero_counts(); nbufe = 0; nfrme = 0; nwr = 0; endtask

  task automatic send(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx[i % 256] = 8'(seed + 7 * i);
      in_valid = 1'b1; in_data = 8'(seed + 7 * i); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic settle();
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // ring of four empty descriptors, the fourth wraps
  task automatic restart(input logic [6:0] units);
    @(negedge clk); enable = 1'b0; buf_units = units;
    for (int i = 0; i < 4; i++) set_desc(i, (i == 3) ? 16'hA000 : 16'h8000);
    repeat (2) @(negedge clk);
    enable = 1'b1; rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (5) @(negedge clk);
    zero_counts();
  endtask

  task automatic buf_match(input string tag, input int ba, input int from, input int cnt);
    int bad = 0;
    for (int i = 0; i < cnt; i++) if (mem[ba + i] !== tx[from + i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 rx_active", rx_active, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 events", {evt_buf, evt_frame}, 0);
  endtask

  task automatic t_discard();
    @(negedge clk); enable = 1'b1;
    for (int i = 0; i < 4; i++) set_desc(i, 16'h8000);
    zero_counts();
    send(8, 3); settle();
    chk("R3 no writes", nwr, 0);
    chk("R3 no events", nbufe + nfrme, 0);
    chk("R3 desc0 untouched", rd16(dsc(0)), 16'h8000);
    chk("R3 still inactive", rx_active, 0);
  endtask

  task automatic t_activate();
    @(negedge clk); enable = 1'b0;
    set_desc(0, 16'h0000);
    repeat (2) @(negedge clk);
    enable = 1'b1; rx_kick = 1'b1; @(negedge clk); rx_kick = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 full desc keeps inactive", rx_active, 0);
    restart(7'd2);
    chk("R2 empty desc activates", rx_active, 1);
  endtask

  task automatic t_single();
    logic [31:0] c;
    restart(7'd2);
    send(10, 17);
    chk("R13 ready low after last", in_ready, 0);
    settle();
    c = ref_crc(10);
    chk("R4 len", rd16(dsc(0)+2), 14);
    chk("R8 flags", rd16(dsc(0)), 16'h0800);
    buf_match("R4 data", bfa(0), 0, 10);
    chk("R5 crc", {mem[bfa(0)+10], mem[bfa(0)+11], mem[bfa(0)+12], mem[bfa(0)+13]}, c);
    chk("R8 evt_frame", nfrme, 1);
    chk("R8 evt_buf", nbufe, 0);
    chk("R12 next empty stays active", rx_active, 1);
  endtask

  task automatic t_split(input logic [6:0] units, input string tag);
    logic [31:0] c;
    restart(units);
    send(14, 40); settle();
    c = ref_crc(14);
    chk({tag, " d0 len"}, rd16(dsc(0)+2), 16);
    chk({tag, " d0 flags"}, rd16(dsc(0)), 16'h0000);
    chk({tag, " d1 len"}, rd16(dsc(1)+2), 2);
    chk({tag, " d1 flags"}, rd16(dsc(1)), 16'h0800);
    buf_match({tag, " data"}, bfa(0), 0, 14);
    chk({tag, " crc split"}, {mem[bfa(0)+14], mem[bfa(0)+15], mem[bfa(1)], mem[bfa(1)+1]}, c);
    chk({tag, " events"}, {nbufe[7:0], nfrme[7:0]}, 16'h0101);
  endtask

  task automatic t_default_size();
    restart(7'd0);
    send(40, 9); settle();
    chk("R6 zero units single desc len", rd16(dsc(0)+2), 44);
    chk("R6 zero units flags", rd16(dsc(0)), 16'h0800);
  endtask

  task automatic t_wrap_drop();
    logic [31:0] c;
    restart(7'd1);
    send(40, 5); settle();
    chk("R6 d2 len", rd16(dsc(2)+2), 12);
    zero_counts();
    send(20, 60); settle();
    chk("R7 drop no writes", nwr, 0);
    chk("R7 d3 untouched", rd16(dsc(3)), 16'hA000);
    chk("R7 stays active", rx_active, 1);
    @(negedge clk); set_desc(0, 16'h8000);
    zero_counts();
    send(20, 61); settle();
    c = ref_crc(20);
    chk("R9 d3 flags", rd16(dsc(3)), 16'h2000);
    chk("R9 d3 len", rd16(dsc(3)+2), 16);
    chk("R9 wrapped d0 len", rd16(dsc(0)+2), 8);
    chk("R9 wrapped d0 flags", rd16(dsc(0)), 16'h0800);
    buf_match("R9 data", bfa(3), 0, 16);
    chk("R9 crc", {mem[bfa(0)+4], mem[bfa(0)+5], mem[bfa(0)+6], mem[bfa(0)+7]}, c);
  endtask

  task automatic t_long();
    len_limit = 16'd20;
    restart(7'd2);
    send(16, 2); settle();
    chk("R10 at limit no flag", rd16(dsc(0)), 16'h0800);
    send(17, 3); settle();
    chk("R10 over limit", rd16(dsc(1)), 16'h0820);
    len_limit = 16'd30;
    restart(7'd1);
    send(30, 4); settle();
    chk("R10 first not flagged", rd16(dsc(0)), 16'h0000);
    chk("R10 middle not flagged", rd16(dsc(1)), 16'h0000);
    chk("R10 last flagged", rd16(dsc(2)), 16'h0820);
    len_limit = 16'hFFFF;
  endtask

  task automatic t_trunc();
    logic [31:0] c;
    restart(7'd4);
    send(100, 11); settle();
    c = ref_crc(MAXF - 4);
    chk("R11 d0 len", rd16(dsc(0)+2), 64);
    chk("R11 d1 len", rd16(dsc(1)+2), 32);
    chk("R11 d1 flags", rd16(dsc(1)), 16'h0821);
    buf_match("R11 data", bfa(1), 64, 28);
    chk("R11 crc", {mem[bfa(1)+28], mem[bfa(1)+29], mem[bfa(1)+30], mem[bfa(1)+31]}, c);
  endtask

  task automatic t_stop_and_off();
    @(negedge clk); enable = 1'b0; buf_units = 7'd2;
    set_desc(0, 16'h8000); set_desc(1, 16'h0000);
    repeat (2) @(negedge clk);
    enable = 1'b1; rx_kick = 1'b1; @(negedge clk); rx_kick = 1'b0;
    repeat (5) @(negedge clk);
    send(10, 1); settle();
    chk("R12 next full goes inactive", rx_active, 0);
    zero_counts();
    send(6, 2); settle();
    chk("R12 later frame not stored", nwr, 0);
    chk("R12 d1 untouched", rd16(dsc(1)), 16'h0000);
    restart(7'd2);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    chk("R2 disable clears active", rx_active, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_discard();
    t_activate();
    t_single();
    t_split(7'd1, "R8");
    t_split(7'd1, "R6");
    t_default_size();
    t_wrap_drop();
    t_long();
    t_trunc();
    t_stop_and_off();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule